// File: doc/BRIEF.md
# Serial Link Word Framer and Scrambler

This block sits between a parallel video source and a downstream 8b/10b line coder. On the send side it takes one payload word and one forward control-channel bit, packs them into a fixed-width link word and sets a trailing even-parity bit. It then XORs the word with the keystream of a free-running additive scrambler and hands it over one byte at a time through a valid/ready handshake. A run-time select picks the short (24-bit) or long (32-bit) word format for each word.

The receive side takes bytes from the line decoder, removes the keystream with its own matching scrambler and rebuilds the word. It returns the payload and the control bit with a one-cycle strobe, and it flags the word if the parity check fails. A link-start pulse puts both scramblers back to the shared seed and drops any word that is only partly moved, so both ends of the link begin in step.

Top module: `link_framer`

## Requirements
- R1: Framing. A short word holds payload bits 21..0 in bits 21..0, the control bit in bit 22 and parity in bit 23. A long word holds payload bits 29..0 in bits 29..0, the control bit in bit 30 and parity in bit 31. A tx_mode_long value of 1 selects the long format.
- R2: Parity is even. The parity bit makes the XOR of every bit of the framed word equal to 0.
- R3: Each sent byte equals the framed byte XOR 8 keystream bits. Keystream bit k, for byte bit k (LSB first), is bit 15 of a 16-bit state. After each bit the state shifts left and takes in the XOR of its bits 15, 4, 3 and 2 (x^16+x^5+x^4+x^3+1). The seed is 16'hACE1. The state advances 8 steps for each byte that moves, and the receive copy follows the same rule.
- R4: A short word leaves as 3 bytes and a long word as 4 bytes, least significant byte first.
- R5: lnk_byte and lnk_valid hold while lnk_valid is high and lnk_ready is low. tx_ready is low from the cycle after a word is accepted until its last byte has moved.
- R6: The send side latches the format when it accepts a word. The receive side latches it, from rx_mode_long, on the first byte of a word. A change of the select during a word does not affect that word.
- R7: A link_start pulse reseeds both scramblers. It abandons any partly sent or partly received word, so lnk_valid is 0 and no word is delivered in the next cycle.
- R8: The cycle after the last byte of a word arrives on the receive side, rx_word_valid is high for exactly one cycle, with the descrambled payload and control bit.
- R9: rx_par_err is high, together with rx_word_valid, when the XOR of the descrambled word is 1. The payload and control bit are still delivered.
- R10: In the short format, tx_payload bits 29..22 have no effect, and rx_payload bits 29..22 are 0.
- R11: After reset, lnk_valid, rx_word_valid and rx_par_err are 0 and tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_start | input | 1 | Pulse: reseed both scramblers, drop partial words |
| tx_mode_long | input | 1 | Send format select, 1 = 32-bit |
| tx_valid | input | 1 | Payload word offered |
| tx_ready | output | 1 | Framer idle, word will be taken |
| tx_payload | input | 30 | Payload word |
| tx_ctrl | input | 1 | Forward control-channel bit |
| lnk_valid | output | 1 | Scrambled byte available |
| lnk_ready | input | 1 | Line coder takes the byte |
| lnk_byte | output | 8 | Scrambled byte |
| rx_mode_long | input | 1 | Receive format select, 1 = 32-bit |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received scrambled byte |
| rx_word_valid | output | 1 | One-cycle strobe: word rebuilt |
| rx_payload | output | 30 | Rebuilt payload |
| rx_ctrl | output | 1 | Rebuilt control bit |
| rx_par_err | output | 1 | Parity failure on this word |

## Verification
On every cycle the assertions check the handshake hold on the byte port, the busy window of tx_ready, the clean stop after a link-start pulse, and that the delivery strobe is a single cycle with the error flag never outside it. They also check that the scrambler state never reaches zero. Bit placement, parity, keystream values, byte order, format latching at word boundaries and the masking of unused payload bits can only be shown by the bench. Its reference model predicts every byte and every rebuilt word. It drives looped-back traffic with random back-pressure, toggles the format select during words, flips single bits on the wire and fires link-start pulses in the middle of words.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;

   typedef enum logic {
      FMT_SHORT = 1'b0,
      FMT_LONG  = 1'b1
   } fmt_e;

   function automatic fmt_e fmt_of(input logic long_sel);
      return long_sel ? FMT_LONG : FMT_SHORT;
   endfunction

endpackage

// File: rtl/lf_lfsr.sv
module lf_lfsr #(
   parameter int                 LFSR_W = 16,
   parameter logic [LFSR_W-1:0]  TAPS   = 16'h801C,
   parameter logic [LFSR_W-1:0]  SEED   = 16'hACE1,
   parameter int                 STEP   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reseed,
   input  logic            advance,
   output logic [STEP-1:0] ks
);

   if (SEED == '0) begin : g_bad_seed
      $error("lf_lfsr: SEED must be nonzero");
   end
   if (TAPS[LFSR_W-1] != 1'b1) begin : g_bad_taps
      $error("lf_lfsr: TAPS must include the top bit");
   end

   logic [LFSR_W-1:0] st;
   logic [LFSR_W-1:0] chain [0:STEP];

   assign chain[0] = st;

   for (genvar i = 0; i < STEP; i++) begin : g_step
      assign ks[i]       = chain[i][LFSR_W-1];
      assign chain[i+1]  = {chain[i][LFSR_W-2:0], ^(chain[i] & TAPS)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st <= SEED;
      else if (reseed)  st <= SEED;
      else if (advance) st <= chain[STEP];
   end

   assert_state_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0);

endmodule

// File: rtl/lf_tx.sv
module lf_tx
   import link_framer_pkg::*;
#(
   parameter int                W_SHORT = 24,
   parameter int                W_LONG  = 32,
   parameter int                BYTE_W  = 8,
   parameter int                LFSR_W  = 16,
   parameter logic [LFSR_W-1:0] TAPS    = 16'h801C,
   parameter logic [LFSR_W-1:0] SEED    = 16'hACE1,
   localparam int               PAY_W   = W_LONG - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_start,
   input  logic              mode_long,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PAY_W-1:0]  in_payload,
   input  logic              in_ctrl,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_byte
);

   localparam int NB_S  = W_SHORT / BYTE_W;
   localparam int NB_L  = W_LONG / BYTE_W;
   localparam int CNT_W = $clog2(NB_L);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(NB_S - 1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(NB_L - 1);

   logic              busy;
   fmt_e              cur_fmt;
   logic [CNT_W-1:0]  idx;
   logic [W_LONG-1:0] shreg;
   logic [W_LONG-1:0] frame;
   logic [BYTE_W-1:0] ks;
   logic              take, move, last;

   assign in_ready  = !busy;
   assign out_valid = busy;
   assign take      = in_valid && !busy && !link_start;
   assign move      = busy && out_ready && !link_start;
   assign last      = idx == ((cur_fmt == FMT_LONG) ? LAST_L : LAST_S);
   assign out_byte  = shreg[BYTE_W-1:0] ^ ks;

   always_comb begin
      frame = '0;
      if (mode_long) begin
         frame[PAY_W-1:0] = in_payload;
         frame[W_LONG-2]  = in_ctrl;
         frame[W_LONG-1]  = ^{in_ctrl, in_payload};
      end else begin
         frame[W_SHORT-3:0] = in_payload[W_SHORT-3:0];
         frame[W_SHORT-2]   = in_ctrl;
         frame[W_SHORT-1]   = ^{in_ctrl, in_payload[W_SHORT-3:0]};
      end
   end

   lf_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED), .STEP(BYTE_W)) u_scr (
      .clk    (clk),
      .rst_n  (rst_n),
      .reseed (link_start),
      .advance(move),
      .ks     (ks)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         shreg   <= '0;
         cur_fmt <= FMT_SHORT;
      end else if (link_start) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (take) begin
         busy    <= 1'b1;
         idx     <= '0;
         shreg   <= frame;
         cur_fmt <= fmt_of(mode_long);
      end else if (move) begin
         shreg <= shreg >> BYTE_W;
         if (last) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || link_start)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

   assert_busy_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n || link_start)
      (in_valid && in_ready) |=> (out_valid && !in_ready));

   assert_start_drops_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_start |=> !out_valid);

endmodule

// File: rtl/lf_rx.sv
module lf_rx
   import link_framer_pkg::*;
#(
   parameter int                W_SHORT = 24,
   parameter int                W_LONG  = 32,
   parameter int                BYTE_W  = 8,
   parameter int                LFSR_W  = 16,
   parameter logic [LFSR_W-1:0] TAPS    = 16'h801C,
   parameter logic [LFSR_W-1:0] SEED    = 16'hACE1,
   localparam int               PAY_W   = W_LONG - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_start,
   input  logic              mode_long,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              out_valid,
   output logic [PAY_W-1:0]  out_payload,
   output logic              out_ctrl,
   output logic              out_par_err
);

   localparam int NB_S  = W_SHORT / BYTE_W;
   localparam int NB_L  = W_LONG / BYTE_W;
   localparam int CNT_W = $clog2(NB_L);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(NB_S - 1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(NB_L - 1);

   logic [CNT_W-1:0]  idx;
   fmt_e              cur_fmt, eff_fmt;
   logic [W_LONG-1:0] acc, full;
   logic [BYTE_W-1:0] ks, plain;
   logic              step, last;

   assign step    = in_valid && !link_start;
   assign plain   = in_byte ^ ks;
   assign eff_fmt = (idx == '0) ? fmt_of(mode_long) : cur_fmt;
   assign last    = idx == ((eff_fmt == FMT_LONG) ? LAST_L : LAST_S);

   always_comb begin
      full = acc;
      for (int j = 0; j < NB_L; j++) begin
         if (idx == CNT_W'(j)) full[j*BYTE_W +: BYTE_W] = plain;
      end
   end

   lf_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED), .STEP(BYTE_W)) u_dscr (
      .clk    (clk),
      .rst_n  (rst_n),
      .reseed (link_start),
      .advance(step),
      .ks     (ks)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx         <= '0;
         acc         <= '0;
         cur_fmt     <= FMT_SHORT;
         out_valid   <= 1'b0;
         out_par_err <= 1'b0;
         out_payload <= '0;
         out_ctrl    <= 1'b0;
      end else begin
         out_valid   <= 1'b0;
         out_par_err <= 1'b0;
         if (link_start) begin
            idx <= '0;
            acc <= '0;
         end else if (step) begin
            if (last) begin
               idx         <= '0;
               acc         <= '0;
               out_valid   <= 1'b1;
               out_par_err <= ^full;
               if (eff_fmt == FMT_LONG) begin
                  out_payload <= full[PAY_W-1:0];
                  out_ctrl    <= full[W_LONG-2];
               end else begin
                  out_payload <= PAY_W'(full[W_SHORT-3:0]);
                  out_ctrl    <= full[W_SHORT-2];
               end
            end else begin
               acc <= full;
               idx <= idx + 1'b1;
               if (idx == '0) cur_fmt <= eff_fmt;
            end
         end
      end
   end

   assert_err_in_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_par_err |-> out_valid);

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_start_drops_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_start |=> !out_valid);

endmodule

// File: rtl/link_framer.sv
module link_framer #(
   parameter int                W_SHORT = 24,
   parameter int                W_LONG  = 32,
   parameter int                BYTE_W  = 8,
   parameter int                LFSR_W  = 16,
   parameter logic [LFSR_W-1:0] TAPS    = 16'h801C,
   parameter logic [LFSR_W-1:0] SEED    = 16'hACE1,
   localparam int               PAY_W   = W_LONG - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_start,
   input  logic              tx_mode_long,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [PAY_W-1:0]  tx_payload,
   input  logic              tx_ctrl,
   output logic              lnk_valid,
   input  logic              lnk_ready,
   output logic [BYTE_W-1:0] lnk_byte,
   input  logic              rx_mode_long,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              rx_word_valid,
   output logic [PAY_W-1:0]  rx_payload,
   output logic              rx_ctrl,
   output logic              rx_par_err
);

   if (W_SHORT % BYTE_W != 0 || W_LONG % BYTE_W != 0) begin : g_bad_width
      $error("link_framer: word widths must be whole bytes");
   end
   if (W_SHORT >= W_LONG) begin : g_bad_order
      $error("link_framer: short word must be narrower than long word");
   end
   if (W_SHORT / BYTE_W < 2) begin : g_bad_short
      $error("link_framer: short word needs at least two bytes");
   end

   lf_tx #(.W_SHORT(W_SHORT), .W_LONG(W_LONG), .BYTE_W(BYTE_W),
           .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_start(link_start),
      .mode_long (tx_mode_long),
      .in_valid  (tx_valid),
      .in_ready  (tx_ready),
      .in_payload(tx_payload),
      .in_ctrl   (tx_ctrl),
      .out_valid (lnk_valid),
      .out_ready (lnk_ready),
      .out_byte  (lnk_byte)
   );

   lf_rx #(.W_SHORT(W_SHORT), .W_LONG(W_LONG), .BYTE_W(BYTE_W),
           .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_start (link_start),
      .mode_long  (rx_mode_long),
      .in_valid   (rx_valid),
      .in_byte    (rx_byte),
      .out_valid  (rx_word_valid),
      .out_payload(rx_payload),
      .out_ctrl   (rx_ctrl),
      .out_par_err(rx_par_err)
   );

endmodule

// File: tb/link_framer_bench.sv
`timescale 1ns/1ps
module link_framer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_start = 1'b0;
   logic        tx_mode_long = 1'b0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [29:0] tx_payload = '0;
   logic        tx_ctrl = 1'b0;
   logic        lnk_valid;
   logic        lnk_ready = 1'b0;
   logic [7:0]  lnk_byte;
   logic        rx_mode_long = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_word_valid;
   logic [29:0] rx_payload;
   logic        rx_ctrl;
   logic        rx_par_err;

   always #2 clk = ~clk;

   link_framer u_link_framer (.*);

   int n_cmp = 0;
   int n_bad = 0;
   int n_words = 0;
   int n_errs = 0;

   // model state
   int unsigned     q_tx[$];   // {first[10], long[9], last[8], byte[7:0]}
   logic [31:0]     q_word[$];
   logic [32:0]     q_rx[$];   // {long, word}
   logic [15:0]     m_lfsr = 16'hACE1;
   logic [31:0]     flip_acc = '0;
   int              byte_k = 0;
   bit              expect_out = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] make_frame(input logic [29:0] pay, input logic c,
                                              input logic lng);
      logic [31:0] w = '0;
      if (lng) begin
         w[29:0] = pay;
         w[30]   = c;
      end else begin
         w[21:0] = pay[21:0];
         w[22]   = c;
      end
      if (lng) w[31] = ^w[30:0];
      else     w[23] = ^w[22:0];
      return w;
   endfunction

   function automatic logic [7:0] key8(input logic [15:0] s_in, output logic [15:0] s_out);
      logic [15:0] s = s_in;
      logic [7:0]  k;
      for (int b = 0; b < 8; b++) begin
         k[b] = s[15];
         s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
      end
      s_out = s;
      return k;
   endfunction

   task automatic cycle(input int p_valid, input int p_ready, input int mode_sel,
                        input int p_flip, input bit start);
      bit          fire, acc_ok;
      int unsigned ent;
      logic [7:0]  exp_b, flip;
      logic [15:0] nxt;
      @(negedge clk);
      // outputs produced by the last edge
      chk(rx_word_valid == expect_out, "R8", "word strobe timing", rx_word_valid, expect_out);
      if (rx_word_valid && q_rx.size() > 0) begin
         logic [32:0] e = q_rx.pop_front();
         logic [29:0] ep = e[32] ? e[29:0] : {8'h00, e[21:0]};
         logic        ec = e[32] ? e[30] : e[22];
         logic        ee = ^e[31:0];
         n_words++;
         if (ee) n_errs++;
         chk(rx_payload == ep, e[32] ? "R1" : "R10", "rx payload", rx_payload, ep);
         chk(rx_ctrl == ec, "R1", "rx control bit", rx_ctrl, ec);
         chk(rx_par_err == ee, "R9", "parity flag", rx_par_err, ee);
      end else if (!rx_word_valid) begin
         chk(rx_par_err == 1'b0, "R9", "flag without strobe", rx_par_err, 0);
      end
      chk(lnk_valid == (q_tx.size() > 0), "R5", "lnk_valid", lnk_valid, q_tx.size() > 0);
      chk(tx_ready == (q_tx.size() == 0), "R5", "tx_ready", tx_ready, q_tx.size() == 0);
      // new inputs
      link_start   = start;
      tx_valid     = !start && ($urandom_range(99) < p_valid);
      tx_payload   = 30'($urandom);
      tx_ctrl      = 1'($urandom);
      tx_mode_long = (mode_sel == 2) ? 1'($urandom) : 1'(mode_sel);
      lnk_ready    = !start && ($urandom_range(99) < p_ready);
      rx_valid     = 1'b0;
      rx_mode_long = 1'($urandom);
      rx_byte      = 8'($urandom);
      expect_out   = 1'b0;
      if (start) begin
         q_tx.delete();
         q_word.delete();
         flip_acc = '0;
         byte_k   = 0;
         m_lfsr   = 16'hACE1;
         return;
      end
      fire   = lnk_valid && lnk_ready;
      acc_ok = tx_valid && tx_ready;
      if (fire) begin
         ent   = q_tx.pop_front();
         exp_b = key8(m_lfsr, nxt) ^ ent[7:0];
         m_lfsr = nxt;
         chk(lnk_byte == exp_b, "R3", "scrambled byte", lnk_byte, exp_b);
         flip = ($urandom_range(99) < p_flip) ? (8'd1 << $urandom_range(7)) : 8'd0;
         rx_valid     = 1'b1;
         rx_byte      = lnk_byte ^ flip;
         rx_mode_long = ent[10] ? ent[9] : !ent[9];
         flip_acc     = flip_acc | (32'(flip) << (8 * byte_k));
         byte_k++;
         if (ent[8]) begin
            logic [31:0] w = q_word.pop_front();
            q_rx.push_back({ent[9], w ^ flip_acc});
            flip_acc   = '0;
            byte_k     = 0;
            expect_out = 1'b1;
         end
      end
      if (acc_ok) begin
         logic [31:0] w  = make_frame(tx_payload, tx_ctrl, tx_mode_long);
         int          nb = tx_mode_long ? 4 : 3;
         q_word.push_back(w);
         for (int k = 0; k < nb; k++) begin
            q_tx.push_back({21'd0, (k == 0), tx_mode_long, (k == nb - 1), w[8*k +: 8]});
         end
      end
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(lnk_valid == 1'b0, "R11", "lnk_valid in reset", lnk_valid, 0);
      chk(tx_ready == 1'b1, "R11", "tx_ready in reset", tx_ready, 1);
      chk(rx_word_valid == 1'b0, "R11", "rx_word_valid in reset", rx_word_valid, 0);
      chk(rx_par_err == 1'b0, "R11", "rx_par_err in reset", rx_par_err, 0);
      rst_n = 1'b1;
      // R1 R2 R4: short words, full throughput
      repeat (300) cycle(100, 100, 0, 0, 1'b0);
      // R1 R4: long words
      repeat (300) cycle(100, 100, 1, 0, 1'b0);
      // R5 R6: back-pressure and format toggled every cycle
      repeat (1500) cycle(60, 50, 2, 0, 1'b0);
      // R9: single-bit corruption on the wire
      repeat (1500) cycle(70, 80, 2, 15, 1'b0);
      // R7: link-start pulses inside words
      for (int r = 0; r < 20; r++) begin
         repeat (37 + r) cycle(80, 70, 2, 5, 1'b0);
         cycle(0, 0, 2, 0, 1'b1);
      end
      // drain
      repeat (40) cycle(0, 100, 2, 0, 1'b0);
      chk(q_rx.size() == 0, "R8", "undelivered words", q_rx.size(), 0);
      chk(n_words > 500, "R8", "words delivered", n_words, 500);
      chk(n_errs > 0, "R9", "flagged words seen", n_errs, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule